// File: doc/BRIEF.md
# Edge-Triggered Interrupt Source Delivery Controller

This block keeps the delivery state of a single interrupt source whose input signals events by rising edges. A rising edge on the source line is latched as a pending request, and the request is then offered to a presentation layer together with the source's 8-bit priority. The presentation layer answers with either an accept or a reject.

After an accept, the source masks itself. It will not offer the interrupt again until an end-of-interrupt (EOI) arrives for it. The source is edge-based, so nothing replays a lost event. For this reason, an edge that arrives while the source waits for its EOI is remembered in a one-bit re-arm flag and becomes a fresh pending request as soon as the EOI lands. A rejected request returns to pending after a programmable back-off delay.

Software can also mask the source explicitly. While the explicit mask is set, a pending request is held and is not offered. Any edge that was first captured during the mask is treated as stale and is thrown away when the mask is lifted.

Top module: `irq_edge_source`

## Requirements
- R1: After a synchronous reset, `state_o` is 0 (idle), `present_valid` is 0, `present_prio` is 0 and the back-off length is DEFAULT_DELAY (16).
- R2: States are encoded on `state_o` as idle=0, pending=1, presented=2, accepted=3, reject-wait=4, and no other value appears. A rising edge on `irq_in` in idle gives pending one clock later. An unmasked pending request becomes presented one clock after that, with `present_valid`=1. A level held high produces only one event.
- R3: `accept` while presented moves the block to accepted and drops `present_valid` on the next clock. `present_valid` stays 0 for as long as no EOI arrives.
- R4: `eoi` in the accepted state, with no edge seen during accepted, returns the block to idle.
- R5: A rising edge seen during accepted is kept. After `eoi` the block enters pending on the next clock, and presented on the clock after that.
- R6: `reject` while presented (with `accept` low) enters reject-wait. With back-off length D, the block is pending D clocks after the reject is taken and presented one clock later. A length of 0 behaves as 1.
- R7: While the explicit mask is set (by `mask_set`, cleared by `mask_clr`), a pending request is not presented. A request that was pending for reasons other than a masked edge is presented once the mask is cleared.
- R8: An edge first captured while the explicit mask is set is discarded when the mask is cleared. This applies both in idle and as a re-arm during accepted: the block then returns to idle and stays there without presenting.
- R9: `accept`, `reject` and `eoi` are ignored in any state other than the one that consumes them, and the state seen on `state_o` is unchanged.
- R10: A `prio_wr` pulse loads `prio_wdata` into the priority shown on `present_prio` one clock later. A `delay_wr` pulse loads `delay_wdata` as the new back-off length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 1 | Edge-signalling source line |
| accept | input | 1 | Presentation layer took the request |
| reject | input | 1 | Presentation layer refused the request |
| eoi | input | 1 | End of interrupt for this source |
| mask_set | input | 1 | Set explicit mask |
| mask_clr | input | 1 | Clear explicit mask |
| prio_wr | input | 1 | Priority register write strobe |
| prio_wdata | input | PW | New priority |
| delay_wr | input | 1 | Back-off length write strobe |
| delay_wdata | input | CW | New back-off length in clocks |
| present_valid | output | 1 | Request is being offered |
| present_prio | output | PW | Priority sent with the request |
| state_o | output | 3 | Current delivery state |

## Verification
The bench builds the block with PW=8, CW=8 and DEFAULT_DELAY=16. These widths let it sweep every one of the 256 priority values and check each back-off length from 0 to 20 at its exact cycle, as well as the reset default. Because the widths are this small, each mask and EOI ordering can be walked one clock at a time, including a stale edge seen in idle and one seen during accepted.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PEND  = 3'd1,
    ST_PRES  = 3'd2,
    ST_ACC   = 3'd3,
    ST_RWAIT = 3'd4
  } src_state_t;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/irq_backoff_timer.sv
module irq_backoff_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic          expire
);
  localparam logic [CW-1:0] ONE = CW'(1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                    cnt_q <= '0;
    else if (load)              cnt_q <= (load_val == '0) ? ONE : load_val;
    else if (run && cnt_q > ONE) cnt_q <= cnt_q - ONE;
  end

  assign expire = (cnt_q <= ONE);
endmodule

// File: rtl/irq_src_cfg.sv
module irq_src_cfg #(
  parameter int PW            = 8,
  parameter int CW            = 8,
  parameter int DEFAULT_DELAY = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prio_wr,
  input  logic [PW-1:0] prio_wdata,
  input  logic          delay_wr,
  input  logic [CW-1:0] delay_wdata,
  output logic [PW-1:0] prio_q,
  output logic [CW-1:0] delay_q
);
  localparam logic [CW-1:0] DELAY_RST = CW'(DEFAULT_DELAY);

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q  <= '0;
      delay_q <= DELAY_RST;
    end else begin
      if (prio_wr)  prio_q  <= prio_wdata;
      if (delay_wr) delay_q <= delay_wdata;
    end
  end
endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
  import irq_src_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rise,
  input  logic       accept,
  input  logic       reject,
  input  logic       eoi,
  input  logic       mask_set,
  input  logic       mask_clr,
  input  logic       tmr_expire,
  output logic       tmr_load,
  output logic       tmr_run,
  output logic       mask_q,
  output logic       present_q,
  output src_state_t state_q
);
  src_state_t state_d;
  logic rearm_q, rearm_d;
  logic ghost_q, ghost_d;
  logic mask_d, unmask;

  assign unmask = mask_clr & ~mask_set & mask_q;
  assign mask_d = mask_set ? 1'b1 : (mask_clr ? 1'b0 : mask_q);

  always_comb begin
    state_d  = state_q;
    rearm_d  = rearm_q;
    ghost_d  = ghost_q;
    tmr_load = 1'b0;
    tmr_run  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (rise) begin
          state_d = ST_PEND;
          ghost_d = mask_q;
        end
      end
      ST_PEND: begin
        if (!mask_q) state_d = ST_PRES;
      end
      ST_PRES: begin
        if (accept) begin
          state_d = ST_ACC;
        end else if (reject) begin
          state_d  = ST_RWAIT;
          tmr_load = 1'b1;
        end
      end
      ST_ACC: begin
        if (eoi) begin
          rearm_d = 1'b0;
          if (rearm_q || rise) begin
            state_d = ST_PEND;
            if (!rearm_q) ghost_d = mask_q;
          end else begin
            state_d = ST_IDLE;
            ghost_d = 1'b0;
          end
        end else if (rise) begin
          rearm_d = 1'b1;
          if (!rearm_q) ghost_d = mask_q;
        end
      end
      ST_RWAIT: begin
        tmr_run = 1'b1;
        if (tmr_expire) state_d = ST_PEND;
      end
      default: state_d = ST_IDLE;
    endcase

    if (unmask && ghost_q) begin
      ghost_d = 1'b0;
      rearm_d = 1'b0;
      if (state_q == ST_PEND)                         state_d = ST_IDLE;
      else if (state_q == ST_ACC && eoi && !rise)     state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      rearm_q   <= 1'b0;
      ghost_q   <= 1'b0;
      mask_q    <= 1'b0;
      present_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      rearm_q   <= rearm_d;
      ghost_q   <= ghost_d;
      mask_q    <= mask_d;
      present_q <= (state_d == ST_PRES);
    end
  end
endmodule

// File: rtl/irq_edge_source.sv
module irq_edge_source
  import irq_src_pkg::*;
#(
  parameter int PW            = 8,
  parameter int CW            = 8,
  parameter int DEFAULT_DELAY = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq_in,
  input  logic          accept,
  input  logic          reject,
  input  logic          eoi,
  input  logic          mask_set,
  input  logic          mask_clr,
  input  logic          prio_wr,
  input  logic [PW-1:0] prio_wdata,
  input  logic          delay_wr,
  input  logic [CW-1:0] delay_wdata,
  output logic          present_valid,
  output logic [PW-1:0] present_prio,
  output logic [2:0]    state_o
);
  logic          rise;
  logic          tmr_load, tmr_run, tmr_expire;
  logic          mask_q;
  logic [CW-1:0] delay_q;
  src_state_t    state_q;

  irq_edge_det u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (irq_in),
    .rise (rise)
  );

  irq_src_cfg #(.PW(PW), .CW(CW), .DEFAULT_DELAY(DEFAULT_DELAY)) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .prio_wr     (prio_wr),
    .prio_wdata  (prio_wdata),
    .delay_wr    (delay_wr),
    .delay_wdata (delay_wdata),
    .prio_q      (present_prio),
    .delay_q     (delay_q)
  );

  irq_backoff_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (delay_q),
    .run      (tmr_run),
    .expire   (tmr_expire)
  );

  irq_src_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .rise       (rise),
    .accept     (accept),
    .reject     (reject),
    .eoi        (eoi),
    .mask_set   (mask_set),
    .mask_clr   (mask_clr),
    .tmr_expire (tmr_expire),
    .tmr_load   (tmr_load),
    .tmr_run    (tmr_run),
    .mask_q     (mask_q),
    .present_q  (present_valid),
    .state_q    (state_q)
  );

  assign state_o = state_q;
endmodule

// File: rtl/irq_edge_source_chk.sv
module irq_edge_source_chk (
  input logic       clk,
  input logic       rst,
  input logic       present_valid,
  input logic       accept,
  input logic       reject,
  input logic       eoi,
  input logic       mask_active,
  input logic [2:0] state_o
);
  AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (rst)
    state_o <= 3'd4); // R2

  AST_ACCEPT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd2 && accept) |=> (state_o == 3'd3 && !present_valid)); // R3

  AST_NO_REPRESENT: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd3 && !eoi) |=> !present_valid); // R3

  AST_EOI_EXIT: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd3 && eoi) |=> (state_o == 3'd0 || state_o == 3'd1)); // R4

  AST_REJECT_WAIT: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd2 && reject && !accept) |=> state_o == 3'd4); // R6

  AST_MASK_BLOCK: assert property (@(posedge clk) disable iff (rst)
    $rose(present_valid) |-> !$past(mask_active)); // R7
endmodule

bind irq_edge_source irq_edge_source_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .present_valid (present_valid),
  .accept        (accept),
  .reject        (reject),
  .eoi           (eoi),
  .mask_active   (mask_q),
  .state_o       (state_o)
);

// File: tb/tb_irq_edge_source.sv
module tb_irq_edge_source;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int CW = 8;
  localparam int DEF_DELAY = 16;
  localparam int WD_LIMIT = 100000;
  localparam int S_IDLE = 0, S_PEND = 1, S_PRES = 2, S_ACC = 3, S_RWAIT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_in = 0, accept = 0, reject = 0, eoi = 0;
  logic mask_set = 0, mask_clr = 0, prio_wr = 0, delay_wr = 0;
  logic [PW-1:0] prio_wdata = '0;
  logic [CW-1:0] delay_wdata = '0;
  logic present_valid;
  logic [PW-1:0] present_prio;
  logic [2:0] state_o;

  int total = 0;
  int fails = 0;
  int cycles = 0;

  irq_edge_source #(.PW(PW), .CW(CW), .DEFAULT_DELAY(DEF_DELAY)) dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .accept(accept), .reject(reject),
    .eoi(eoi), .mask_set(mask_set), .mask_clr(mask_clr), .prio_wr(prio_wr),
    .prio_wdata(prio_wdata), .delay_wr(delay_wr), .delay_wdata(delay_wdata),
    .present_valid(present_valid), .present_prio(present_prio), .state_o(state_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles == WD_LIMIT) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
    accept = 0; reject = 0; eoi = 0; mask_set = 0; mask_clr = 0;
    prio_wr = 0; delay_wr = 0;
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_st(string tag, int st, int pv);
    chk({tag, " state"}, int'(state_o), st);
    chk({tag, " present_valid"}, int'(present_valid), pv);
  endtask

  task automatic raise_edge();
    irq_in = 1; step(); irq_in = 0;
  endtask

  task automatic to_presented(string tag);
    raise_edge();
    chk_st({tag, " R2 pend"}, S_PEND, 0);
    step();
    chk_st({tag, " R2 pres"}, S_PRES, 1);
  endtask

  task automatic finish_accept();
    accept = 1; step();
    eoi = 1; step();
  endtask

  task automatic wr_delay(int d);
    delay_wdata = CW'(d); delay_wr = 1; step();
  endtask

  task automatic reject_run(string tag, int d);
    int eff;
    eff = (d == 0) ? 1 : d;
    to_presented(tag);
    reject = 1; step();
    chk_st({tag, " R6 wait"}, S_RWAIT, 0);
    for (int j = 1; j < eff; j++) begin
      step();
      chk_st({tag, " R6 still waiting"}, S_RWAIT, 0);
    end
    step();
    chk_st({tag, " R6 back to pend"}, S_PEND, 0);
    step();
    chk_st({tag, " R6 represented"}, S_PRES, 1);
    finish_accept();
    chk_st({tag, " R4 idle"}, S_IDLE, 0);
  endtask

  initial begin
    step(); step();
    rst = 0;
    step();
    // R1 reset state
    chk_st("R1 reset", S_IDLE, 0);
    chk("R1 prio reset", int'(present_prio), 0);

    // R2 single event from held level; R3 no re-present; R4 eoi to idle
    irq_in = 1; step();
    chk_st("R2 held pend", S_PEND, 0);
    step();
    chk_st("R2 held pres", S_PRES, 1);
    accept = 1; step();
    chk_st("R3 accepted", S_ACC, 0);
    for (int k = 0; k < 10; k++) begin
      step();
      chk_st("R3 hold no present", S_ACC, 0);
    end
    eoi = 1; step();
    chk_st("R4 eoi idle", S_IDLE, 0);
    for (int k = 0; k < 4; k++) begin
      step();
      chk_st("R2 level gives one event", S_IDLE, 0);
    end
    irq_in = 0; step();

    // R5 rearm during accepted
    to_presented("R5");
    accept = 1; step();
    raise_edge();
    chk_st("R5 edge in acc", S_ACC, 0);
    step();
    eoi = 1; step();
    chk_st("R5 after eoi pend", S_PEND, 0);
    step();
    chk_st("R5 presented", S_PRES, 1);
    finish_accept();
    chk_st("R5 done idle", S_IDLE, 0);

    // R6 reject with default delay, then R10 delay sweep
    reject_run("R6 default", DEF_DELAY);
    for (int d = 0; d <= 20; d++) begin
      wr_delay(d);
      reject_run("R10 delay", d);
    end

    // R7 pending (not from masked edge) held by mask then presented
    wr_delay(3);
    to_presented("R7");
    reject = 1; step();
    mask_set = 1; step();
    for (int k = 0; k < 6; k++) step();
    chk_st("R7 masked pending", S_PEND, 0);
    mask_clr = 1; step();
    chk_st("R7 unmask cycle", S_PEND, 0);
    step();
    chk_st("R7 presented after unmask", S_PRES, 1);
    finish_accept();

    // R8 masked edge in idle is discarded
    mask_set = 1; step();
    raise_edge();
    chk_st("R8 masked edge pend", S_PEND, 0);
    step(); step();
    chk_st("R8 not presented", S_PEND, 0);
    mask_clr = 1; step();
    chk_st("R8 dropped", S_IDLE, 0);
    for (int k = 0; k < 3; k++) begin
      step();
      chk_st("R8 stays idle", S_IDLE, 0);
    end

    // R8 masked rearm edge during accepted is discarded
    to_presented("R8 acc");
    accept = 1; step();
    mask_set = 1; step();
    raise_edge();
    eoi = 1; step();
    chk_st("R8 rearm pend", S_PEND, 0);
    mask_clr = 1; step();
    chk_st("R8 rearm dropped", S_IDLE, 0);
    step(); step();
    chk_st("R8 rearm stays idle", S_IDLE, 0);

    // R7 unmasked rearm kept across mask
    to_presented("R7 acc");
    accept = 1; step();
    raise_edge();
    mask_set = 1; step();
    eoi = 1; step();
    chk_st("R7 rearm pend", S_PEND, 0);
    mask_clr = 1; step();
    chk_st("R7 rearm unmask cycle", S_PEND, 0);
    step();
    chk_st("R7 rearm presented", S_PRES, 1);
    finish_accept();

    // R9 stray commands ignored
    eoi = 1; step();
    chk_st("R9 eoi idle", S_IDLE, 0);
    accept = 1; step();
    chk_st("R9 accept idle", S_IDLE, 0);
    reject = 1; step();
    chk_st("R9 reject idle", S_IDLE, 0);
    to_presented("R9");
    accept = 1; step();
    accept = 1; step();
    chk_st("R9 accept in acc", S_ACC, 0);
    reject = 1; step();
    chk_st("R9 reject in acc", S_ACC, 0);
    eoi = 1; step();
    chk_st("R9 back idle", S_IDLE, 0);

    // R10 priority sweep
    for (int p = 0; p < 256; p++) begin
      prio_wdata = PW'(p); prio_wr = 1; step();
      chk("R10 prio", int'(present_prio), p);
    end
    prio_wdata = 8'h5A; prio_wr = 1; step();
    to_presented("R10 prio pres");
    chk("R10 prio with request", int'(present_prio), 8'h5A);
    finish_accept();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule